// File: doc/BRIEF.md
# Threshold Wake-Up Power Controller

This block sets the power-save state of a handful of signal-path stages in a radio baseband. While the receiver sits in standby, it compares an 8-bit auxiliary level reading against a threshold set by the host. If the reading rises above the threshold, the block pulls an active-low interrupt. When auto-start is enabled and the bias supply is on, it also brings the receive path up on its own.

Stages never come on together. The converter stage is enabled first, then the filter stage, and the output stage last. A programmable number of clocks separates each step. The programmed spacing is limited so that the whole ramp completes inside a fixed wake-up deadline of 400 µs at the configured clock.

The host drives the block through single-cycle commands: a general reset, receive or transmit activation, threshold and configuration writes, a spacing write, an interrupt clear, and crystal on or off. The crystal clock enable is the only output that survives resets. It is turned off only by its own command.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `en_xtal` is 1. Every other enable and both mode outputs are 0, and `irq_n` is 1.
- R2: Command opcode 1 (general reset) returns the block to sleep. It clears configuration, interrupt, mode and stage enables, sets the threshold to all ones, and leaves `en_xtal` unchanged.
- R3: `en_xtal` is cleared only by opcode 7 and set by opcode 8. Each takes effect one cycle after the command. `rst` sets it; opcode 1 leaves it as it is.
- R4: In standby, with the armed bit (configuration bit 1) set, a level strictly greater than the threshold (opcode 4, low 8 bits) pulls `irq_n` low two cycles after the level is presented. A level equal to or below the threshold, or an unarmed block, leaves `irq_n` high.
- R5: `irq_n` stays low until opcode 6 clears it. While the interrupt is pending, a level above the threshold does not start a wake-up.
- R6: An auto wake happens on a crossing only when configuration bit 2 (auto-start) and bit 0 (bias, also driven on `en_bias`) are both set. An auto wake runs the staged ramp and selects receive mode.
- R7: The ramp spacing is d clocks, set by opcode 9. After the wake-up decision, `en_adc` rises 1 cycle later, `en_filt` d+1 cycles after `en_adc`, and `en_out` d+1 cycles after `en_filt`. The stages rise in that order.
- R8: A spacing above (CLK_MHZ*400-3)/2 is clamped to that value. This keeps the ramp within CLK_MHZ*400 cycles.
- R9: Configuration bit 3 holds `en_adc` high through sleep, independently of the ramp.
- R10: Opcode 2 (receive) and opcode 3 (transmit) start the same ramp from sleep and set exactly one of `mode_rx`/`mode_tx`. Issued while awake, they switch the mode without restarting the ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command opcode |
| cmd_data | input | DLY_W | Command argument |
| level | input | LVL_W | Auxiliary level reading |
| irq_n | output | 1 | Active-low threshold interrupt |
| en_xtal | output | 1 | Crystal clock enable |
| en_bias | output | 1 | Bias generator enable |
| en_adc | output | 1 | Converter stage enable |
| en_filt | output | 1 | Filter stage enable |
| en_out | output | 1 | Output stage enable |
| mode_rx | output | 1 | Receive mode active |
| mode_tx | output | 1 | Transmit mode active |

## Verification
The assertions assume that commands are single-cycle strobes. They also assume that `cmd_op` carries one of the ten defined opcodes whenever `cmd_valid` is high. The deadline property assumes the spacing register can hold the clamp limit for the chosen clock.

The stimulus issues every command as a one-cycle pulse and changes `level` only on falling edges. It also sweeps thresholds and levels inside the 8-bit range, so the assertions' view of a command matches what the design decodes.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_GRST = 4'd1,
    OP_RX   = 4'd2,
    OP_TX   = 4'd3,
    OP_THR  = 4'd4,
    OP_CFG  = 4'd5,
    OP_ICLR = 4'd6,
    OP_XOFF = 4'd7,
    OP_XON  = 4'd8,
    OP_DLY  = 4'd9
  } op_e;

  // packed: keep_adc is bit 3, bias is bit 0
  typedef struct packed {
    logic keep_adc;
    logic auto_go;
    logic armed;
    logic bias;
  } cfg_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ONE  = 2'd1,
    PH_TWO  = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

endpackage

// File: rtl/pwr_lvl_cmp.sv
module pwr_lvl_cmp #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             thr_we,
  input  logic [LVL_W-1:0] thr_d,
  input  logic [LVL_W-1:0] level,
  output logic             above
);

  logic [LVL_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      thr_q <= '1;
      above <= 1'b0;
    end else begin
      if (thr_we) thr_q <= thr_d;
      above <= (level > thr_q);
    end
  end

endmodule

// File: rtl/pwr_stage_seq.sv
module pwr_stage_seq
  import pwr_wake_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  output logic             st_adc,
  output logic             st_filt,
  output logic             st_out,
  output logic             busy
);

  phase_e           ph_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      st_adc  <= 1'b0;
      st_filt <= 1'b0;
      st_out  <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start) begin
          st_adc <= 1'b1;
          cnt_q  <= dly;
          ph_q   <= PH_ONE;
        end
        PH_ONE: if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          st_filt <= 1'b1;
          cnt_q   <= dly;
          ph_q    <= PH_TWO;
        end
        PH_TWO: if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          st_out <= 1'b1;
          ph_q   <= PH_DONE;
        end
        default: ;
      endcase
    end
  end

  assign busy = (ph_q == PH_ONE) || (ph_q == PH_TWO);

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int LVL_W   = 8,
  parameter int DLY_W   = 16,
  parameter int CLK_MHZ = 200,
  parameter int WAKE_US = 400,
  parameter int DLY_RST = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [DLY_W-1:0] cmd_data,
  input  logic [LVL_W-1:0] level,
  output logic             irq_n,
  output logic             en_xtal,
  output logic             en_bias,
  output logic             en_adc,
  output logic             en_filt,
  output logic             en_out,
  output logic             mode_rx,
  output logic             mode_tx
);

  localparam int DEADLINE_CYC = CLK_MHZ * WAKE_US;
  localparam int MAX_DLY      = (DEADLINE_CYC - 3) / 2;
  localparam logic [DLY_W-1:0] MAX_DLY_V = DLY_W'(MAX_DLY);
  localparam logic [DLY_W-1:0] RST_DLY_V =
    (DLY_RST > MAX_DLY) ? MAX_DLY_V : DLY_W'(DLY_RST);

  op_e op;
  assign op = op_e'(cmd_op);

  logic is_grst, is_rx, is_tx, is_thr, is_cfg, is_iclr, is_xoff, is_xon, is_dly;
  assign is_grst = cmd_valid && (op == OP_GRST);
  assign is_rx   = cmd_valid && (op == OP_RX);
  assign is_tx   = cmd_valid && (op == OP_TX);
  assign is_thr  = cmd_valid && (op == OP_THR);
  assign is_cfg  = cmd_valid && (op == OP_CFG);
  assign is_iclr = cmd_valid && (op == OP_ICLR);
  assign is_xoff = cmd_valid && (op == OP_XOFF);
  assign is_xon  = cmd_valid && (op == OP_XON);
  assign is_dly  = cmd_valid && (op == OP_DLY);

  cfg_t             cfg_q;
  logic [DLY_W-1:0] dly_q;
  logic             xtal_q, rx_q, tx_q, pend_q;
  logic             above, standby, hit, wake, start;
  logic             st_adc, st_filt, st_out, seq_busy;

  pwr_lvl_cmp #(.LVL_W(LVL_W)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .clr    (is_grst),
    .thr_we (is_thr),
    .thr_d  (cmd_data[LVL_W-1:0]),
    .level  (level),
    .above  (above)
  );

  assign standby = !rx_q && !tx_q;
  assign hit     = standby && cfg_q.armed && above && !pend_q;
  assign wake    = hit && cfg_q.auto_go && cfg_q.bias;
  assign start   = standby && (is_rx || is_tx || wake);

  pwr_stage_seq #(.DLY_W(DLY_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .clr     (is_grst),
    .start   (start),
    .dly     (dly_q),
    .st_adc  (st_adc),
    .st_filt (st_filt),
    .st_out  (st_out),
    .busy    (seq_busy)
  );

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      xtal_q <= 1'b1;
    end else if (is_xoff) begin
      xtal_q <= 1'b0;
    end else if (is_xon) begin
      xtal_q <= 1'b1;
    end

    if (rst || is_grst) begin
      cfg_q  <= '0;
      dly_q  <= RST_DLY_V;
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (is_cfg) cfg_q <= cfg_t'(cmd_data[3:0]);
      if (is_dly) dly_q <= (cmd_data > MAX_DLY_V) ? MAX_DLY_V : cmd_data;
      if (is_rx) begin
        rx_q <= 1'b1;
        tx_q <= 1'b0;
      end else if (is_tx) begin
        rx_q <= 1'b0;
        tx_q <= 1'b1;
      end else if (wake) begin
        rx_q <= 1'b1;
      end
      if (hit)          pend_q <= 1'b1;
      else if (is_iclr) pend_q <= 1'b0;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n   <= 1'b1;
      en_xtal <= 1'b1;
      en_bias <= 1'b0;
      en_adc  <= 1'b0;
      en_filt <= 1'b0;
      en_out  <= 1'b0;
      mode_rx <= 1'b0;
      mode_tx <= 1'b0;
    end else begin
      irq_n   <= !pend_q;
      en_xtal <= xtal_q;
      en_bias <= cfg_q.bias;
      en_adc  <= st_adc || cfg_q.keep_adc;
      en_filt <= st_filt;
      en_out  <= st_out;
      mode_rx <= rx_q;
      mode_tx <= tx_q;
    end
  end

endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk #(
  parameter int DEADLINE_CYC = 80000
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       irq_n,
  input logic       en_xtal,
  input logic       en_bias,
  input logic       en_adc,
  input logic       en_filt,
  input logic       en_out,
  input logic       mode_rx,
  input logic       mode_tx,
  input logic       busy
);

  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= 0;
    else              busy_cnt <= busy_cnt + 1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_xtal && irq_n && !en_bias && !en_adc && !en_filt
                    && !en_out && !mode_rx && !mode_tx));

  // R3
  xtal_off_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(en_xtal) |-> $past(cmd_valid && cmd_op == 4'd7, 2));

  // R5
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> $past(cmd_valid && (cmd_op == 4'd6 || cmd_op == 4'd1), 2));

  // R7
  filt_after_adc_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en_filt) |-> en_adc);

  // R7
  out_after_filt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en_out) |-> en_filt);

  // R8
  ramp_deadline_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt <= DEADLINE_CYC));

  // R10
  one_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mode_rx, mode_tx}));

endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.DEADLINE_CYC(DEADLINE_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .irq_n     (irq_n),
  .en_xtal   (en_xtal),
  .en_bias   (en_bias),
  .en_adc    (en_adc),
  .en_filt   (en_filt),
  .en_out    (en_out),
  .mode_rx   (mode_rx),
  .mode_tx   (mode_tx),
  .busy      (seq_busy)
);

// File: tb/pwr_wake_ctrl_tb.sv
module pwr_wake_ctrl_tb;

  localparam int LVL_W   = 8;
  localparam int DLY_W   = 16;
  localparam int CLK_MHZ = 2;
  localparam int MAXD    = (CLK_MHZ * 400 - 3) / 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_valid = 1'b0;
  logic [3:0]       cmd_op = '0;
  logic [DLY_W-1:0] cmd_data = '0;
  logic [LVL_W-1:0] level = '0;
  logic irq_n, en_xtal, en_bias, en_adc, en_filt, en_out, mode_rx, mode_tx;

  int checks = 0;
  int errors = 0;
  int t_adc, t_filt, t_out, t_irq;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_wake_ctrl #(.LVL_W(LVL_W), .DLY_W(DLY_W), .CLK_MHZ(CLK_MHZ)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .level(level), .irq_n(irq_n), .en_xtal(en_xtal),
    .en_bias(en_bias), .en_adc(en_adc), .en_filt(en_filt), .en_out(en_out),
    .mode_rx(mode_rx), .mode_tx(mode_tx)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input int data);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = DLY_W'(data);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // stimulus already placed at a falling edge; count edges to first rise
  task automatic track(input int maxn);
    t_adc = -1; t_filt = -1; t_out = -1; t_irq = -1;
    for (int k = 1; k <= maxn; k++) begin
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (en_adc  && t_adc  < 0) t_adc  = k;
      if (en_filt && t_filt < 0) t_filt = k;
      if (en_out  && t_out  < 0) t_out  = k;
      if (!irq_n  && t_irq  < 0) t_irq  = k;
    end
  endtask

  task automatic cmd_track(input logic [3:0] op, input int data, input int maxn);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = DLY_W'(data);
    track(maxn);
  endtask

  task automatic lvl_track(input int lv, input int maxn);
    @(negedge clk);
    level = LVL_W'(lv);
    track(maxn);
  endtask

  task automatic clean();
    @(negedge clk);
    level = '0;
    issue(4'd1, 0);
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 outputs", {en_xtal, irq_n, en_bias, en_adc, en_filt, en_out, mode_rx, mode_tx},
          8'b1100_0000);

    // R3 crystal control
    issue(4'd1, 0); idle(1);
    check("R3 xtal kept by general reset", en_xtal, 1);
    issue(4'd7, 0); idle(1);
    check("R3 xtal off cmd", en_xtal, 0);
    issue(4'd1, 0); idle(2);
    check("R2 R3 general reset keeps xtal off", en_xtal, 0);
    issue(4'd8, 0); idle(1);
    check("R3 xtal on cmd", en_xtal, 1);
    issue(4'd7, 0); idle(1);
    @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    check("R1 reset restores xtal", en_xtal, 1);

    // R7 R10 staged ramp sweep on receive command
    for (int d = 0; d <= 5; d++) begin
      clean();
      issue(4'd9, d);
      cmd_track(4'd2, 0, 2 * d + 10);
      check("R7 adc time", t_adc, 2);
      check("R7 filt time", t_filt, d + 3);
      check("R7 out time", t_out, 2 * d + 4);
      check("R10 rx mode", {mode_rx, mode_tx}, 2'b10);
    end
    // R10 switch while awake, no restart
    issue(4'd3, 0); idle(1);
    check("R10 switch to tx", {mode_rx, mode_tx}, 2'b01);
    check("R10 stages stay on", {en_adc, en_filt, en_out}, 3'b111);
    // R10 transmit from sleep
    clean();
    issue(4'd9, 1);
    cmd_track(4'd3, 0, 12);
    check("R10 tx out time", t_out, 6);
    check("R10 tx mode", {mode_rx, mode_tx}, 2'b01);

    // R8 clamp
    clean();
    issue(4'd9, 16'hFFFF);
    cmd_track(4'd2, 0, 2 * MAXD + 10);
    check("R8 clamped filt time", t_filt, MAXD + 3);
    check("R8 clamped out time", t_out, 2 * MAXD + 4);

    // R4 threshold sweep, armed, no auto start
    for (int ti = 0; ti < 4; ti++) begin
      int thr;
      thr = (ti == 0) ? 0 : (ti == 1) ? 37 : (ti == 2) ? 128 : 254;
      for (int li = 0; li < 4; li++) begin
        int lv;
        lv = (li == 0) ? thr - 1 : (li == 1) ? thr : (li == 2) ? thr + 1 : 255;
        if (lv < 0) continue;
        clean();
        issue(4'd4, thr);
        issue(4'd5, 4'b0010);
        lvl_track(lv, 6);
        check("R4 irq timing", t_irq, (lv > thr) ? 3 : -1);
        check("R4 no wake without auto", t_adc, -1);
      end
    end
    clean();
    issue(4'd4, 10);
    lvl_track(200, 6);
    check("R4 unarmed no irq", t_irq, -1);

    // R5 pending interrupt blocks wake until cleared
    clean();
    issue(4'd9, 2);
    issue(4'd4, 50);
    issue(4'd5, 4'b0010);
    lvl_track(100, 6);
    check("R5 irq raised", t_irq, 3);
    issue(4'd5, 4'b0111);
    idle(10);
    check("R5 irq held", irq_n, 0);
    check("R5 no wake while pending", {en_adc, mode_rx}, 2'b00);
    cmd_track(4'd6, 0, 14);
    check("R5 wake after clear adc", t_adc, 3);
    check("R5 wake after clear out", t_out, 9);
    check("R6 auto wake selects rx", mode_rx, 1);

    // R6 bias gating
    clean();
    issue(4'd4, 50);
    issue(4'd5, 4'b0110);
    lvl_track(100, 10);
    check("R6 irq without bias", t_irq, 3);
    check("R6 no wake without bias", t_adc, -1);
    check("R6 bias output off", en_bias, 0);
    clean();
    issue(4'd9, 0);
    issue(4'd4, 50);
    issue(4'd5, 4'b0111);
    lvl_track(100, 10);
    check("R6 bias output on", en_bias, 1);
    check("R6 auto adc", t_adc, 3);
    check("R6 auto filt", t_filt, 4);
    check("R6 auto out", t_out, 5);
    check("R6 auto irq", t_irq, 3);

    // R2 general reset clears everything but crystal
    issue(4'd1, 0); idle(1);
    check("R2 cleared", {en_xtal, irq_n, en_bias, en_adc, en_filt, en_out, mode_rx, mode_tx},
          8'b1100_0000);

    // R9 keep converter powered in sleep
    clean();
    issue(4'd5, 4'b1000); idle(1);
    check("R9 adc held in sleep", {en_adc, en_filt, en_out}, 3'b100);
    issue(4'd1, 0); idle(1);
    check("R9 released by general reset", en_adc, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule